// File: doc/BRIEF.md
# Clock Rate Measurement Sequencer

This block produces the frequency of a selected clock in hertz. It needs no software. On a request it drives an external reference-timed frequency counter through two runs. The short run lasts 0x1000 reference ticks and the full run lasts 0x10000 reference ticks. If both runs return the same raw count, the counter never advanced, so the clock under test is taken to be stopped. Otherwise the full count goes through a fixed-point correction, and a multi-cycle divider turns it into a rate.

A requester raises a one-cycle request together with a flag that says whether the chosen clock can be measured. The block answers with a one-cycle acknowledge. It holds a signed 32-bit result until the next acknowledge. The result is -1 when the clock cannot be measured, 0 for a stopped clock, and otherwise the rate in Hz. The rate saturates at the largest positive 32-bit value.

The block talks to the counter through a write port and two status inputs. The write port carries a write strobe, a run bit and a tick preset. The status inputs are a completion flag and the raw count.

Top module: `clk_rate_meter`

## Requirements
- R1: While reset is held and right after it, `ack_o` is 0, `result_o` is 0 and no counter write is issued.
- R2: When the clock cannot be measured (`supported_i` = 0 with the request), the block acknowledges with `result_o` = 32'hFFFF_FFFF (-1) and writes nothing to the counter.
- R3: Each run issues three counter writes in this order:
  - a stop write (`cnt_ctl_run_o` = 0) with the tick preset;
  - a start write (`cnt_ctl_run_o` = 1) with the same preset, issued only after `cnt_done_i` has been seen low;
  - a second stop write, issued only after `cnt_done_i` has been seen high.

  The raw count is sampled after the second stop write.
- R4: A measured request makes exactly two runs. The short run uses preset 0x1000 and comes first; the full run uses preset 0x10000. That gives six counter writes per request.
- R5: If the full and short raw counts are equal, the result is 0.
- R6: Otherwise the result is floor(((full*10 + 15) * 4800000) / (0x10000*10 + 35)). The intermediate is 64 bits and the division is a restoring division.
- R7: A quotient above 0x7FFF_FFFF gives the result 0x7FFF_FFFF.
- R8: `ack_o` is a single-cycle pulse, raised only once the quotient is final. `result_o` changes only in the cycle `ack_o` rises and then holds.
- R9: A request that arrives while a measurement is in progress is ignored. It adds no acknowledge and no counter writes after the current sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Measurement request pulse |
| supported_i | input | 1 | Selected clock can be measured (sampled with the request) |
| ack_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Signed result: rate in Hz, 0 for stopped, -1 for unsupported |
| cnt_ctl_we_o | output | 1 | Counter control write strobe |
| cnt_ctl_run_o | output | 1 | Run bit of the control write |
| cnt_ctl_ticks_o | output | TICK_W | Reference tick preset of the control write |
| cnt_done_i | input | 1 | Counter completion flag |
| cnt_count_i | input | CNT_W | Raw count of the last run |

## Verification
The in-line properties check every cycle that:
- a start write follows a low completion flag and a capture follows a stop write;
- the divider remainder is below the divisor when it finishes;
- the acknowledge is a single pulse that follows the divider's completion;
- the result holds between acknowledges;
- unsupported, stopped and saturating cases produce -1, 0 and the maximum value.

Only the bench scenarios can show the rest:
- the exact rate for chosen counts;
- that the short preset precedes the full one;
- that each request issues exactly six writes;
- that a request during a busy sequence leaves no trace.

// File: rtl/clkmeas_pkg.sv
package clkmeas_pkg;

  localparam int unsigned WIDE_W = 64;
  localparam int unsigned RES_W  = 32;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_STOP, SQ_WRDY, SQ_START, SQ_WDONE, SQ_HALT, SQ_CAP
  } seq_state_t;

  typedef enum logic [1:0] {
    TP_IDLE, TP_SHORT, TP_FULL, TP_DIV
  } top_state_t;

  // Corrected numerator: (count*mul + add) * scale, 64-bit wide
  function automatic logic [WIDE_W-1:0] rate_numerator(
    input logic [WIDE_W-1:0] count,
    input int unsigned       mul,
    input int unsigned       add,
    input int unsigned       scale
  );
    logic [WIDE_W-1:0] t;
    t = count * WIDE_W'(mul) + WIDE_W'(add);
    return t * WIDE_W'(scale);
  endfunction

  // Clamp an unsigned wide quotient to the largest positive 32-bit value
  function automatic logic [RES_W-1:0] clamp_pos(input logic [WIDE_W-1:0] q);
    logic [WIDE_W-1:0] lim;
    lim = WIDE_W'({1'b0, {(RES_W-1){1'b1}}});
    if (q > lim) return {1'b0, {(RES_W-1){1'b1}}};
    return q[RES_W-1:0];
  endfunction

endpackage

// File: rtl/clkmeas_run.sv
module clkmeas_run
  import clkmeas_pkg::*;
#(
  parameter int unsigned CNT_W  = 25,
  parameter int unsigned TICK_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [TICK_W-1:0] ticks_i,
  input  logic              cnt_done_i,
  input  logic [CNT_W-1:0]  cnt_count_i,
  output logic              ctl_we_o,
  output logic              ctl_run_o,
  output logic [TICK_W-1:0] ctl_ticks_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o
);

  seq_state_t        state_q;
  logic [TICK_W-1:0] ticks_q;
  logic [CNT_W-1:0]  count_q;
  logic              done_q;
  logic              capture_w;

  assign capture_w   = (state_q == SQ_CAP);
  assign ctl_we_o    = (state_q == SQ_STOP) || (state_q == SQ_START) || (state_q == SQ_HALT);
  assign ctl_run_o   = (state_q == SQ_START);
  assign ctl_ticks_o = ticks_q;
  assign done_o      = done_q;
  assign count_o     = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ticks_q <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (go_i) begin
          ticks_q <= ticks_i;
          state_q <= SQ_STOP;
        end
        SQ_STOP:  state_q <= SQ_WRDY;
        SQ_WRDY:  if (!cnt_done_i) state_q <= SQ_START;
        SQ_START: state_q <= SQ_WDONE;
        SQ_WDONE: if (cnt_done_i) state_q <= SQ_HALT;
        SQ_HALT:  state_q <= SQ_CAP;
        SQ_CAP: begin
          count_q <= cnt_count_i;
          done_q  <= 1'b1;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_START_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we_o && ctl_run_o) |-> !$past(cnt_done_i)); // R3

  AST_CAPTURE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |-> $past(ctl_we_o && !ctl_run_o)); // R3

endmodule

// File: rtl/clkmeas_div.sv
module clkmeas_div #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, rem_q, dsr_q;
  logic [CW-1:0] left_q;
  logic          busy_q, done_q;
  logic [W:0]    shifted_w;
  logic          fits_w;
  logic [W:0]    diff_w;
  logic [W-1:0]  rem_next_w;

  assign shifted_w  = {rem_q, quo_q[W-1]};
  assign fits_w     = (shifted_w >= {1'b0, dsr_q});
  assign diff_w     = shifted_w - {1'b0, dsr_q};
  assign rem_next_w = fits_w ? diff_w[W-1:0] : shifted_w[W-1:0];
  assign done_o     = done_q;
  assign quot_o     = quo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        quo_q  <= dividend_i;
        rem_q  <= '0;
        dsr_q  <= divisor_i;
        left_q <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= rem_next_w;
        quo_q  <= {quo_q[W-2:0], fits_w};
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < dsr_q)); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q)); // R8

endmodule

// File: rtl/clk_rate_meter.sv
module clk_rate_meter
  import clkmeas_pkg::*;
#(
  parameter int unsigned CNT_W       = 25,
  parameter int unsigned TICK_W      = 17,
  parameter int unsigned SHORT_TICKS = 32'h0000_1000,
  parameter int unsigned FULL_TICKS  = 32'h0001_0000,
  parameter int unsigned CNT_MUL     = 10,
  parameter int unsigned CNT_ADD     = 15,
  parameter int unsigned REF_SCALE   = 4800000,
  parameter int unsigned DEN_ADD     = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              supported_i,
  output logic              ack_o,
  output logic [31:0]       result_o,
  output logic              cnt_ctl_we_o,
  output logic              cnt_ctl_run_o,
  output logic [TICK_W-1:0] cnt_ctl_ticks_o,
  input  logic              cnt_done_i,
  input  logic [CNT_W-1:0]  cnt_count_i
);

  localparam logic [WIDE_W-1:0] DIVISOR =
    WIDE_W'(FULL_TICKS) * WIDE_W'(CNT_MUL) + WIDE_W'(DEN_ADD);
  localparam logic [RES_W-1:0]  RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0]  RES_NEG1 = '1;

  top_state_t         state_q;
  logic [CNT_W-1:0]   short_q;
  logic [RES_W-1:0]   result_q;
  logic               ack_q;

  logic               run_go_w, run_done_w;
  logic [TICK_W-1:0]  run_ticks_w;
  logic [CNT_W-1:0]   run_count_w;
  logic               accept_w, unsup_w, full_done_w, dead_w, div_start_w, div_done_w;
  logic [WIDE_W-1:0]  numer_w, div_quot_w;

  assign accept_w    = (state_q == TP_IDLE) && req_i;
  assign unsup_w     = accept_w && !supported_i;
  assign full_done_w = (state_q == TP_FULL) && run_done_w;
  assign dead_w      = full_done_w && (run_count_w == short_q);
  assign div_start_w = full_done_w && (run_count_w != short_q);
  assign run_go_w    = (accept_w && supported_i) || ((state_q == TP_SHORT) && run_done_w);
  assign run_ticks_w = (state_q == TP_IDLE) ? TICK_W'(SHORT_TICKS) : TICK_W'(FULL_TICKS);
  assign numer_w     = rate_numerator(WIDE_W'(run_count_w), CNT_MUL, CNT_ADD, REF_SCALE);

  clkmeas_run #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (run_go_w),
    .ticks_i     (run_ticks_w),
    .cnt_done_i  (cnt_done_i),
    .cnt_count_i (cnt_count_i),
    .ctl_we_o    (cnt_ctl_we_o),
    .ctl_run_o   (cnt_ctl_run_o),
    .ctl_ticks_o (cnt_ctl_ticks_o),
    .done_o      (run_done_w),
    .count_o     (run_count_w)
  );

  clkmeas_div #(.W(WIDE_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start_w),
    .dividend_i (numer_w),
    .divisor_i  (DIVISOR),
    .done_o     (div_done_w),
    .quot_o     (div_quot_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= TP_IDLE;
      short_q  <= '0;
      result_q <= '0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (state_q)
        TP_IDLE: if (accept_w) begin
          if (!supported_i) begin
            result_q <= RES_NEG1;
            ack_q    <= 1'b1;
          end else begin
            state_q <= TP_SHORT;
          end
        end
        TP_SHORT: if (run_done_w) begin
          short_q <= run_count_w;
          state_q <= TP_FULL;
        end
        TP_FULL: if (run_done_w) begin
          if (dead_w) begin
            result_q <= '0;
            ack_q    <= 1'b1;
            state_q  <= TP_IDLE;
          end else begin
            state_q <= TP_DIV;
          end
        end
        TP_DIV: if (div_done_w) begin
          result_q <= clamp_pos(div_quot_w);
          ack_q    <= 1'b1;
          state_q  <= TP_IDLE;
        end
        default: state_q <= TP_IDLE;
      endcase
    end
  end

  assign ack_o    = ack_q;
  assign result_o = result_q;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o); // R8

  AST_ACK_AFTER_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    div_done_w |=> ack_o); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> $stable(result_o)); // R8

  AST_UNSUP_NEG1: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_w |=> (ack_o && result_o == RES_NEG1)); // R2

  AST_UNSUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_w |=> !cnt_ctl_we_o); // R2

  AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dead_w |=> (ack_o && result_o == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done_w && div_quot_w > WIDE_W'(RES_MAX)) |=> (result_o == RES_MAX)); // R7

endmodule

// File: tb/tb_clk_rate_meter.sv
module tb_clk_rate_meter;

  localparam int unsigned CNT_W  = 25;
  localparam int unsigned TICK_W = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_i = 1'b0;
  logic              supported_i = 1'b0;
  logic              ack_o;
  logic [31:0]       result_o;
  logic              cnt_ctl_we_o, cnt_ctl_run_o;
  logic [TICK_W-1:0] cnt_ctl_ticks_o;
  logic              cnt_done_i;
  logic [CNT_W-1:0]  cnt_count_i;

  always #5 clk = ~clk;

  clk_rate_meter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .supported_i(supported_i),
    .ack_o(ack_o), .result_o(result_o),
    .cnt_ctl_we_o(cnt_ctl_we_o), .cnt_ctl_run_o(cnt_ctl_run_o),
    .cnt_ctl_ticks_o(cnt_ctl_ticks_o),
    .cnt_done_i(cnt_done_i), .cnt_count_i(cnt_count_i)
  );

  // ---------------- counter model ----------------
  logic [CNT_W-1:0]  val_short = '0, val_full = '0;
  logic              m_done = 1'b0, m_running = 1'b0;
  logic [TICK_W-1:0] m_timer = '0, m_ticks = '0;
  logic [1:0]        m_clr = '0;
  logic [CNT_W-1:0]  m_count = '0;
  assign cnt_done_i  = m_done;
  assign cnt_count_i = m_count;

  always @(posedge clk) begin
    if (cnt_ctl_we_o && !cnt_ctl_run_o) begin
      m_running <= 1'b0;
      m_clr     <= 2'd3;
    end else if (cnt_ctl_we_o && cnt_ctl_run_o) begin
      m_running <= 1'b1;
      m_ticks   <= cnt_ctl_ticks_o;
      m_timer   <= cnt_ctl_ticks_o >> 6;
    end else begin
      if (m_running) begin
        if (m_timer == 0) begin
          m_running <= 1'b0;
          m_done    <= 1'b1;
          m_count   <= (m_ticks == TICK_W'(32'h1000)) ? val_short : val_full;
        end else m_timer <= m_timer - 1'b1;
      end
      if (m_clr != 0) begin
        m_clr <= m_clr - 1'b1;
        if (m_clr == 2'd1) m_done <= 1'b0;
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int n_checks = 0, n_fail = 0;
  int exp_q[$];
  int ack_cnt = 0, wr_cnt = 0, ready_viol = 0;
  logic [TICK_W-1:0] start_log[$];
  logic prev_ack = 1'b0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_rate(input longint unsigned s, input longint unsigned f);
    longint unsigned n, q;
    if (s == f) return 0;
    n = (f * 10 + 15) * 64'd4800000;
    q = n / 64'd655395;
    if (q > 64'd2147483647) return 32'h7FFF_FFFF;
    return int'(q);
  endfunction

  // monitor: compares acknowledged results against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cnt_ctl_we_o) begin
        wr_cnt++;
        if (cnt_ctl_run_o) begin
          start_log.push_back(cnt_ctl_ticks_o);
          if (m_done) ready_viol++;
        end
      end
      if (ack_o) begin
        ack_cnt++;
        if (prev_ack) check(0, "R8 ack longer than one cycle", 1, 0);
        if (exp_q.size() == 0) check(0, "R9 unexpected ack", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check($signed(result_o) == e, "R6/R5/R7/R2 result", $signed(result_o), e);
        end
      end
      prev_ack = ack_o;
    end
  end

  // driver: one request; pushes the expected item, then checks the port-level traffic
  task automatic measure(input bit sup, input int s, input int f, input bit extra_req);
    int a0, w0;
    logic [31:0] held;
    val_short = CNT_W'(s);
    val_full  = CNT_W'(f);
    exp_q.push_back(sup ? model_rate(longint'(s), longint'(f)) : -1);
    a0 = ack_cnt;
    w0 = wr_cnt;
    start_log.delete();
    @(negedge clk);
    supported_i = sup;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    if (extra_req) begin
      repeat (200) @(negedge clk);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
    end
    while (ack_cnt == a0) @(negedge clk);
    held = result_o;
    repeat (60) @(negedge clk);
    check(ack_cnt == a0 + 1, "R9 single ack per accepted request", ack_cnt - a0, 1);
    check(result_o == held, "R8 result holds after ack", result_o, held);
    if (!sup) begin
      check(wr_cnt == w0, "R2 no counter writes when unsupported", wr_cnt - w0, 0);
    end else begin
      check(wr_cnt - w0 == 6, "R4 six counter writes per request", wr_cnt - w0, 6);
      check(start_log.size() == 2, "R4 two runs", start_log.size(), 2);
      if (start_log.size() == 2) begin
        check(start_log[0] == 17'h01000, "R4 short preset first", start_log[0], 32'h1000);
        check(start_log[1] == 17'h10000, "R4 full preset second", start_log[1], 32'h10000);
      end
      check(ready_viol == 0, "R3 start only after done low", ready_viol, 0);
    end
  endtask

  initial begin
    int wr_rst;
    repeat (4) @(negedge clk);
    check(ack_o == 1'b0, "R1 ack low in reset", ack_o, 0);
    check(result_o == 32'd0, "R1 result zero in reset", result_o, 0);
    wr_rst = (cnt_ctl_we_o === 1'b1) ? 1 : 0;
    check(wr_rst == 0, "R1 no write in reset", wr_rst, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ack_o == 1'b0 && wr_cnt == 0, "R1 idle after reset", wr_cnt, 0);

    measure(1'b0, 0, 0, 1'b0);                 // R2
    measure(1'b1, 80000, 1310720, 1'b0);       // R6
    measure(1'b1, 1310720, 1310720, 1'b0);     // R5 stopped clock
    measure(1'b1, 3, 1, 1'b0);                 // R6 small count -> 183
    measure(1'b1, 5, 33554431, 1'b0);          // R7 saturation
    measure(1'b1, 100, 9830400, 1'b1);         // R9 extra request while busy
    measure(1'b1, 0, 0, 1'b0);                 // R5 zero counts
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule